// File: doc/BRIEF.md
# Processor Run-Control State Controller

This block decides whether an embedded processor core is executing. It tracks four operating states: executing, halted by an external debugger, sleeping, and waiting for an operation the program started. The core asks for sleep or wait with single-cycle commands. A wake event ends sleep. A completion strobe ends wait without any outside help. An external hold line can stop the core from any of these states, and when it is released the core always goes back to executing.

The block drives three kinds of output. The first is a run enable for the core pipeline. The second is a 3-bit status code; while halted, this code also shows which state the halt interrupted. The third is a gate on the external debug port. Debug reads and writes of the internal instruction and data memories are forwarded only while halted. A request made in any other state is dropped and answered with a one-cycle error pulse.

Top module: `run_ctl_top`

## Requirements
- R1: While rst_n is low, core_run_en is 0, state_code is 000, mem_req is 0 and dbg_err is 0. On the first rising clock edge after rst_n goes high, the controller enters the executing state (state_code 000, core_run_en 1).
- R2: In the executing state, hold_req moves the controller to the halted state on the next edge. state_code becomes 100 and core_run_en drops to 0.
- R3: In the executing state, slp_cmd moves the controller to sleep (state_code 010). If slp_cmd and wt_cmd arrive together, sleep wins. In sleep, wake_evt returns the controller to executing (000) on the next edge.
- R4: In the executing state, wt_cmd moves the controller to wait (state_code 001). In wait, done_stb returns it to executing on the next edge, with no other input needed.
- R5: Hold entered from sleep reports state_code 110. Hold entered from wait reports 101.
- R6: When hold_req is low in the halted state, the controller returns to executing (000) on the next edge, whichever state the hold interrupted.
- R7: hold_req takes priority over done_stb in wait and over wake_evt in sleep when they arrive in the same cycle.
- R8: Only in the halted state (state_code bit 2 = 1) are dbg_req, dbg_we, dbg_addr and dbg_wdata passed through to mem_req, mem_we, mem_addr and mem_wdata. In every other state these four outputs are 0, and a debug request does not change the state.
- R9: A dbg_req raised outside the halted state makes dbg_err high in the following cycle only. A dbg_req raised in the halted state never raises dbg_err.
- R10: core_run_en is 1 only in the executing state. In sleep, the slp_cmd, wt_cmd and done_stb inputs are ignored. In wait, the slp_cmd, wt_cmd and wake_evt inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| hold_req | input | 1 | External debug halt request, level |
| slp_cmd | input | 1 | Sleep command from the core, one cycle |
| wt_cmd | input | 1 | Wait command from the core, one cycle |
| done_stb | input | 1 | Completion of the awaited operation |
| wake_evt | input | 1 | Wake event for sleep |
| dbg_req | input | 1 | Debug memory access request |
| dbg_we | input | 1 | Debug access is a write |
| dbg_addr | input | AW | Debug access address |
| dbg_wdata | input | DW | Debug write data |
| core_run_en | output | 1 | Core execution enable |
| state_code | output | 3 | Operating status code |
| mem_req | output | 1 | Gated memory access request |
| mem_we | output | 1 | Gated memory write enable |
| mem_addr | output | AW | Gated memory address |
| mem_wdata | output | DW | Gated memory write data |
| dbg_err | output | 1 | One-cycle flag for a dropped debug request |

## Verification
The status code and the run enable are decoded directly from the state register. A wrong state or a wrong hold origin therefore shows up on state_code and core_run_en one clock edge after the input that caused it. A wrong state also changes whether the debug gate is open, so mem_req and dbg_err show the error in the same cycle and in the next one. The sweep starts from every reachable state, including all three hold origins, and applies every combination of the five control inputs. Each transition, and each priority between simultaneous inputs, is therefore checked one edge after it is taken.

// File: rtl/run_ctl_pkg.sv
package run_ctl_pkg;

  typedef enum logic [2:0] {
    OP_OFF   = 3'd0,
    OP_RUN   = 3'd1,
    OP_HOLD  = 3'd2,
    OP_SLEEP = 3'd3,
    OP_WAIT  = 3'd4
  } op_state_e;

  // Origin of a hold; the value is the low two bits of the status code.
  typedef enum logic [1:0] {
    ORG_RUN   = 2'b00,
    ORG_WAIT  = 2'b01,
    ORG_SLEEP = 2'b10
  } hold_org_e;

  localparam logic [2:0] CODE_RUN   = 3'b000;
  localparam logic [2:0] CODE_SLEEP = 3'b010;
  localparam logic [2:0] CODE_WAIT  = 3'b001;
  localparam logic       CODE_HOLD_FLAG = 1'b1;

endpackage

// File: rtl/run_ctl_fsm.sv
module run_ctl_fsm
  import run_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold_req,
  input  logic      slp_cmd,
  input  logic      wt_cmd,
  input  logic      done_stb,
  input  logic      wake_evt,
  output op_state_e state_q,
  output hold_org_e org_q
);

  op_state_e state_d;
  hold_org_e org_d;
  logic      st_en;
  logic      org_en;

  // Next-state logic: a hold request beats every other input.
  always_comb begin
    state_d = state_q;
    org_d   = org_q;
    unique case (state_q)
      OP_OFF: state_d = OP_RUN;
      OP_RUN: begin
        if (hold_req) begin
          state_d = OP_HOLD;
          org_d   = ORG_RUN;
        end else if (slp_cmd) begin
          state_d = OP_SLEEP;
        end else if (wt_cmd) begin
          state_d = OP_WAIT;
        end
      end
      OP_SLEEP: begin
        if (hold_req) begin
          state_d = OP_HOLD;
          org_d   = ORG_SLEEP;
        end else if (wake_evt) begin
          state_d = OP_RUN;
        end
      end
      OP_WAIT: begin
        if (hold_req) begin
          state_d = OP_HOLD;
          org_d   = ORG_WAIT;
        end else if (done_stb) begin
          state_d = OP_RUN;
        end
      end
      OP_HOLD: begin
        if (!hold_req) state_d = OP_RUN;
      end
      default: state_d = OP_OFF;
    endcase
  end

  assign st_en  = (state_d != state_q);
  assign org_en = (org_d != org_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OP_OFF;
    end else if (st_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      org_q <= ORG_RUN;
    end else if (org_en) begin
      org_q <= org_d;
    end
  end

endmodule

// File: rtl/run_ctl_status.sv
module run_ctl_status
  import run_ctl_pkg::*;
(
  input  op_state_e   state_q,
  input  hold_org_e   org_q,
  output logic [2:0]  code,
  output logic        run_en,
  output logic        hold_active
);

  always_comb begin
    code        = CODE_RUN;
    run_en      = 1'b0;
    hold_active = 1'b0;
    unique case (state_q)
      OP_RUN: begin
        code   = CODE_RUN;
        run_en = 1'b1;
      end
      OP_SLEEP: code = CODE_SLEEP;
      OP_WAIT:  code = CODE_WAIT;
      OP_HOLD: begin
        code        = {CODE_HOLD_FLAG, org_q};
        hold_active = 1'b1;
      end
      default: code = CODE_RUN;
    endcase
  end

endmodule

// File: rtl/run_ctl_dbg_gate.sv
module run_ctl_dbg_gate #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant_en,
  input  logic          dbg_req,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          dbg_err
);

  logic err_d;
  logic err_q;

  assign mem_req   = dbg_req & grant_en;
  assign mem_we    = dbg_we & mem_req;
  assign mem_addr  = mem_req ? dbg_addr : '0;
  assign mem_wdata = mem_req ? dbg_wdata : '0;

  assign err_d = dbg_req & ~grant_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign dbg_err = err_q;

endmodule

// File: rtl/run_ctl_top.sv
module run_ctl_top
  import run_ctl_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_req,
  input  logic          slp_cmd,
  input  logic          wt_cmd,
  input  logic          done_stb,
  input  logic          wake_evt,
  input  logic          dbg_req,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic          core_run_en,
  output logic [2:0]    state_code,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          dbg_err
);

  op_state_e state_q;
  hold_org_e org_q;
  logic      hold_active;

  run_ctl_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .slp_cmd  (slp_cmd),
    .wt_cmd   (wt_cmd),
    .done_stb (done_stb),
    .wake_evt (wake_evt),
    .state_q  (state_q),
    .org_q    (org_q)
  );

  run_ctl_status u_status (
    .state_q     (state_q),
    .org_q       (org_q),
    .code        (state_code),
    .run_en      (core_run_en),
    .hold_active (hold_active)
  );

  run_ctl_dbg_gate #(
    .AW (AW),
    .DW (DW)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_en  (hold_active),
    .dbg_req   (dbg_req),
    .dbg_we    (dbg_we),
    .dbg_addr  (dbg_addr),
    .dbg_wdata (dbg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .dbg_err   (dbg_err)
  );

endmodule

// File: rtl/run_ctl_chk.sv
module run_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_req,
  input logic       wt_cmd,
  input logic       slp_cmd,
  input logic       done_stb,
  input logic       wake_evt,
  input logic       dbg_req,
  input logic       core_run_en,
  input logic [2:0] state_code,
  input logic       mem_req,
  input logic       dbg_err
);

  // R2
  run_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run_en && hold_req) |=> (state_code == 3'b100 && !core_run_en));

  // R4
  wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b001 && done_stb && !hold_req) |=> (state_code == 3'b000 && core_run_en));

  // R3
  sleep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run_en && !hold_req && slp_cmd && wt_cmd) |=> (state_code == 3'b010));

  // R7
  hold_prio_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b001 && hold_req) |=> (state_code == 3'b101));

  // R7
  hold_prio_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b010 && hold_req) |=> (state_code == 3'b110));

  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code[2] && !hold_req) |=> (state_code == 3'b000 && core_run_en));

  // R8
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> state_code[2]);

  // R9
  drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !state_code[2]) |=> dbg_err);

  // R9
  no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_req && !state_code[2]) |=> !dbg_err);

  // R10
  run_en_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run_en |-> (state_code == 3'b000));

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b001 && !hold_req && !done_stb) |=> $stable(state_code));

endmodule

bind run_ctl_top run_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_req    (hold_req),
  .wt_cmd      (wt_cmd),
  .slp_cmd     (slp_cmd),
  .done_stb    (done_stb),
  .wake_evt    (wake_evt),
  .dbg_req     (dbg_req),
  .core_run_en (core_run_en),
  .state_code  (state_code),
  .mem_req     (mem_req),
  .dbg_err     (dbg_err)
);

// File: tb/sim_run_ctl_top.sv
module sim_run_ctl_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          hold_req, slp_cmd, wt_cmd, done_stb, wake_evt;
  logic          dbg_req, dbg_we;
  logic [AW-1:0] dbg_addr;
  logic [DW-1:0] dbg_wdata;
  logic          core_run_en;
  logic [2:0]    state_code;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          dbg_err;

  int n_chk = 0;
  int n_err = 0;

  run_ctl_top #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .slp_cmd(slp_cmd),
    .wt_cmd(wt_cmd), .done_stb(done_stb), .wake_evt(wake_evt),
    .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .core_run_en(core_run_en),
    .state_code(state_code), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dbg_err(dbg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    hold_req = 0; slp_cmd = 0; wt_cmd = 0; done_stb = 0; wake_evt = 0;
    dbg_req = 0; dbg_we = 0; dbg_addr = '0; dbg_wdata = '0;
  endtask

  // R1: reset holds outputs quiet, first edge after release executes
  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    clear_in();
    dbg_req = 1;
    step();
    step();
    check("R1 reset run_en", {31'd0, core_run_en}, 0);
    check("R1 reset code", {29'd0, state_code}, 0);
    check("R1 reset mem_req", {31'd0, mem_req}, 0);
    check("R1 reset dbg_err", {31'd0, dbg_err}, 0);
    dbg_req = 0;
    rst_n = 1;
    step();
    check("R1 run after release code", {29'd0, state_code}, 0);
    check("R1 run after release en", {31'd0, core_run_en}, 1);
  endtask

  // Model state: value equals expected status code (0 run,1 wait,2 sleep,4/5/6 hold)
  function automatic logic [2:0] exp_next(input logic [2:0] s, input logic [4:0] v);
    logic h, sl, wt, dn, wk;
    h = v[0]; sl = v[1]; wt = v[2]; dn = v[3]; wk = v[4];
    if (s[2]) return h ? s : 3'b000;
    case (s)
      3'b000: return h ? 3'b100 : sl ? 3'b010 : wt ? 3'b001 : 3'b000;
      3'b010: return h ? 3'b110 : wk ? 3'b000 : 3'b010;
      3'b001: return h ? 3'b101 : dn ? 3'b000 : 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s, input logic [4:0] v);
    if (s[2]) return v[0] ? "R5 hold stays" : "R6 hold release";
    case (s)
      3'b000: return v[0] ? "R2 run->hold" : v[1] ? "R3 run->sleep" : v[2] ? "R4 run->wait" : "R10 run idle";
      3'b010: return v[0] ? (v[4] ? "R7 hold over wake" : "R5 sleep->hold") : v[4] ? "R3 wake" : "R10 sleep ignores";
      default: return v[0] ? (v[3] ? "R7 hold over done" : "R5 wait->hold") : v[3] ? "R4 done" : "R10 wait ignores";
    endcase
  endfunction

  task automatic goto_state(input logic [2:0] s);
    do_reset();
    if (s == 3'b010 || s == 3'b110) begin
      slp_cmd = 1; step(); slp_cmd = 0;
    end else if (s == 3'b001 || s == 3'b101) begin
      wt_cmd = 1; step(); wt_cmd = 0;
    end
    if (s[2]) begin
      hold_req = 1; step();
    end
    check("R5 reach state", {29'd0, state_code}, {29'd0, s});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [2:0] states [6];
    states[0] = 3'b000; states[1] = 3'b001; states[2] = 3'b010;
    states[3] = 3'b100; states[4] = 3'b101; states[5] = 3'b110;
    rst_n = 0;
    clear_in();

    // Transition sweep: every start state, every control input combination
    for (int si = 0; si < 6; si++) begin
      for (int v = 0; v < 32; v++) begin
        logic [2:0] s;
        logic [2:0] e;
        s = states[si];
        goto_state(s);
        hold_req = v[0]; slp_cmd = v[1]; wt_cmd = v[2]; done_stb = v[3]; wake_evt = v[4];
        step();
        e = exp_next(s, v[4:0]);
        check(tag_of(s, v[4:0]), {29'd0, state_code}, {29'd0, e});
        check("R10 run_en", {31'd0, core_run_en}, {31'd0, (e == 3'b000)});
        clear_in();
      end
    end

    // Debug gate sweep: every state, read and write
    for (int si = 0; si < 6; si++) begin
      for (int w = 0; w < 2; w++) begin
        logic [2:0] s;
        logic g;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        s = states[si];
        g = s[2];
        a = AW'(12'h5A3 ^ {9'd0, s});
        d = 32'hC0DE_0000 | {29'd0, s} | (w << 8);
        goto_state(s);
        dbg_req = 1; dbg_we = w[0]; dbg_addr = a; dbg_wdata = d;
        #1;
        check("R8 mem_req", {31'd0, mem_req}, {31'd0, g});
        check("R8 mem_we", {31'd0, mem_we}, {31'd0, g & w[0]});
        check("R8 mem_addr", {20'd0, mem_addr}, g ? {20'd0, a} : 32'd0);
        check("R8 mem_wdata", mem_wdata, g ? d : 32'd0);
        step();
        dbg_req = 0; dbg_we = 0;
        check("R9 err pulse", {31'd0, dbg_err}, {31'd0, ~g});
        check("R8 state kept", {29'd0, state_code}, {29'd0, s});
        step();
        check("R9 err one cycle", {31'd0, dbg_err}, 0);
        clear_in();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule